// File: doc/BRIEF.md
# Board Interrupt-Level Encoder

This block sits on a board-control device. It gathers thirteen level-sensitive interrupt lines from on-board peripherals and folds them into one 4-bit encoded interrupt level for the processor. Each source has a fixed priority level and a fixed bit in a 16-bit pending word and in a 16-bit enable mask. The block reports the most urgent source that is both asserted and enabled. The winning level is inverted, so an idle board drives code zero.

Software reaches the block through a small 64-byte window of 16-bit registers on a simple synchronous bus. The window holds the enable mask, a general-purpose output port that drives a 16-bit external bus, a fixed version word and a power-off control. A power-off write only raises a one-cycle request pulse; whatever acts on that pulse lies outside the block.

Top module: `board_irq_top`

## Requirements
- R1: After reset the enable mask, the output port and the pending word are zero, `irlCode` is 0, `busRdata` is 0 and `powerOffReq` is low.
- R2: Source input `srcIn[i]` sets its pending bit while high and clears it while low. The bit and level for each index are: 0→bit 9/level 1, 1→bit 8/level 2, 2→bit 12/level 3, 3→bit 11/level 0, 4→bit 10/level 4, 5→bit 6/level 5, 6→bit 5/level 6, 7→bit 4/level 7, 8→bit 7/level 8, 9→bit 14/level 9, 10→bit 13/level 10, 11→bit 0/level 11, 12→bit 15/level 12.
- R3: Among the sources whose pending bit and mask bit are both set, the smallest level number wins, and `irlCode` equals that level XOR 15.
- R4: When no source is both pending and enabled, `irlCode` is 0 (level 15 inverted).
- R5: `irlCode` is registered. It reflects the source lines and the mask as they stand at the clock edge, so it changes one clock after either changes, including when both change in the same cycle.
- R6: The mask register is at byte offset 0x00. It can be read and written, and a write takes part in the encoding from the same edge on.
- R7: Offset 0x36 is a read/write output port whose stored value drives `outPort`. Its value holds when it is not written.
- R8: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R9: Offset 0x30 reads 0. A write to it with data bit 0 set raises `powerOffReq` for exactly the one cycle after the write. A write to it with bit 0 clear leaves `powerOffReq` low.
- R10: Any other offset, odd offsets included, reads 0. Writes to those offsets change neither the mask nor the output port.
- R11: Read data appears on `busRdata` in the cycle after the request (`busValid` high, `busWrite` low). In any cycle that follows no read, `busRdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 13 | Level-sensitive interrupt lines, indexed as in R2 |
| busValid | input | 1 | Bus request strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset within the window |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, one cycle after the request |
| outPort | output | 16 | General output port value |
| powerOffReq | output | 1 | One-cycle power-off request pulse |
| irlCode | output | 4 | Encoded interrupt level (winning level XOR 15) |

## Verification
A mask write and a change on the source lines can land on the same clock edge. The encoder has to combine the new mask with the new line values, not either one with a stale copy of the other. The bench provokes this by changing `srcIn` in the same cycle as a mask write. In one case the write unmasks a freshly raised source. In the other it masks a source that is still high while a lower-priority source rises. The expected code one clock later comes from a bench-side table model that sees both updates.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;

  localparam int NUM_SRC = 13;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int LVL_W   = 4;

  localparam logic [ADDR_W-1:0] OFS_MASK    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_POWER   = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_VERSION = 6'h32;
  localparam logic [ADDR_W-1:0] OFS_PORT    = 6'h36;

  localparam logic [WORD_W-1:0] VERSION_VALUE = 16'h0010;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_MASK,
    RD_PORT,
    RD_VERSION
  } rdSel_e;

  // Strobes handed from bus control to the datapath each cycle
  typedef struct packed {
    logic   maskWr;
    logic   portWr;
    logic   rdEn;
    rdSel_e rdSel;
  } busStrobe_t;

  // Position of each source in the pending / mask word
  function automatic int srcBit(input int idx);
    case (idx)
      0:       return 9;
      1:       return 8;
      2:       return 12;
      3:       return 11;
      4:       return 10;
      5:       return 6;
      6:       return 5;
      7:       return 4;
      8:       return 7;
      9:       return 14;
      10:      return 13;
      11:      return 0;
      default: return 15;
    endcase
  endfunction

  // Priority level of each source; lower number is more urgent
  function automatic int srcLevel(input int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 0;
      4:       return 4;
      5:       return 5;
      6:       return 6;
      7:       return 7;
      8:       return 8;
      9:       return 9;
      10:      return 10;
      11:      return 11;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
  import board_irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output busStrobe_t    strobe,
  output logic          powerOffReq
);

  logic wrReq;
  logic rdReq;
  logic powerHit;

  assign wrReq = busValid && busWrite;
  assign rdReq = busValid && !busWrite;

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_ZERO;
    strobe.rdEn   = rdReq;
    powerHit      = 1'b0;
    unique case (busAddr)
      OFS_MASK: begin
        strobe.maskWr = wrReq;
        strobe.rdSel  = RD_MASK;
      end
      OFS_PORT: begin
        strobe.portWr = wrReq;
        strobe.rdSel  = RD_PORT;
      end
      OFS_VERSION: begin
        strobe.rdSel  = RD_VERSION;
      end
      OFS_POWER: begin
        powerHit      = wrReq && busWdata[0];
      end
      default: begin
        strobe.rdSel  = RD_ZERO;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) powerOffReq <= 1'b0;
    else       powerOffReq <= powerHit;
  end

  // R9: a power-off write with bit 0 clear never raises the request
  a_r9_no_spurious_off: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && busAddr == OFS_POWER && !busWdata[0]) |=> !powerOffReq);

  // R9: a request is always preceded by a bus write
  a_r9_off_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |-> $past(wrReq));

  // R10: at most one register is written per request
  a_r10_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.maskWr, strobe.portWr, powerHit}));

endmodule

// File: rtl/board_irq_dpath.sv
module board_irq_dpath
  import board_irq_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int DW = WORD_W,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NS-1:0] srcIn,
  input  busStrobe_t    strobe,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] outPort,
  output logic [LW-1:0] irlCode
);

  localparam int NUM_LVL = 1 << LW;
  localparam logic [LW-1:0] IDLE_LVL = {LW{1'b1}};

  logic [DW-1:0]      monitorQ;
  logic [DW-1:0]      monitorNext;
  logic [DW-1:0]      maskQ;
  logic [DW-1:0]      maskNext;
  logic [DW-1:0]      activeNext;
  logic [NUM_LVL-1:0] byLevel;
  logic [LW-1:0]      selLvl;

  // Scatter the source lines into the pending word
  always_comb begin
    monitorNext = '0;
    for (int i = 0; i < NS; i++) begin
      monitorNext[srcBit(i)] = srcIn[i];
    end
  end

  assign maskNext   = strobe.maskWr ? wdata : maskQ;
  assign activeNext = monitorNext & maskNext;

  // Gather active sources by their priority level
  always_comb begin
    byLevel = '0;
    for (int i = 0; i < NS; i++) begin
      byLevel[srcLevel(i)] = byLevel[srcLevel(i)] | activeNext[srcBit(i)];
    end
  end

  // Lowest set level wins; idle level when none
  always_comb begin
    selLvl = IDLE_LVL;
    for (int l = NUM_LVL - 2; l >= 0; l--) begin
      if (byLevel[l]) selLvl = LW'(l);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      monitorQ <= '0;
      maskQ    <= '0;
      outPort  <= '0;
      irlCode  <= '0;
    end else begin
      monitorQ <= monitorNext;
      maskQ    <= maskNext;
      irlCode  <= selLvl ^ IDLE_LVL;
      if (strobe.portWr) outPort <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (strobe.rdEn) begin
      unique case (strobe.rdSel)
        RD_MASK:    rdata <= maskQ;
        RD_PORT:    rdata <= outPort;
        RD_VERSION: rdata <= VERSION_VALUE;
        default:    rdata <= '0;
      endcase
    end else begin
      rdata <= '0;
    end
  end

  // R4: nothing enabled and pending means a zero code
  a_r4_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    ((monitorQ & maskQ) == '0) |-> (irlCode == '0));

  // R3: the level-0 source, when active, always drives the top code
  a_r3_top_level_wins: assert property (@(posedge clk) disable iff (!rstN)
    (monitorQ[srcBit(3)] && maskQ[srcBit(3)]) |-> (irlCode == IDLE_LVL));

  // R5: a nonzero code implies some stored source is active
  a_r5_code_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    (irlCode != '0) |-> ((monitorQ & maskQ) != '0));

  // R8: the version read returns the fixed word
  a_r8_version_value: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.rdSel == RD_VERSION) |=> (rdata == VERSION_VALUE));

  // R7: the port holds its value unless written
  a_r7_port_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.portWr |=> $stable(outPort));

endmodule

// File: rtl/board_irq_top.sv
module board_irq_top
  import board_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWdata,
  output logic [WORD_W-1:0]   busRdata,
  output logic [WORD_W-1:0]   outPort,
  output logic                powerOffReq,
  output logic [LVL_W-1:0]    irlCode
);

  busStrobe_t strobe;

  board_irq_ctrl #(
    .AW(ADDR_W),
    .DW(WORD_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busValid   (busValid),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .strobe     (strobe),
    .powerOffReq(powerOffReq)
  );

  board_irq_dpath #(
    .NS(NUM_SRC),
    .DW(WORD_W),
    .LW(LVL_W)
  ) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .strobe (strobe),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .outPort(outPort),
    .irlCode(irlCode)
  );

endmodule

// File: tb/board_irq_top_tb.sv
module board_irq_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [12:0] srcIn;
  logic        busValid;
  logic        busWrite;
  logic [5:0]  busAddr;
  logic [15:0] busWdata;
  logic [15:0] busRdata;
  logic [15:0] outPort;
  logic        powerOffReq;
  logic [3:0]  irlCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  board_irq_top dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .outPort(outPort),
    .powerOffReq(powerOffReq), .irlCode(irlCode)
  );

  // Table from R2
  function automatic int tbBit(input int i);
    int t [13] = '{9, 8, 12, 11, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return t[i];
  endfunction

  function automatic int tbLvl(input int i);
    int t [13] = '{1, 2, 3, 0, 4, 5, 6, 7, 8, 9, 10, 11, 12};
    return t[i];
  endfunction

  // R3 / R4 model
  function automatic logic [3:0] expCode(input logic [12:0] s, input logic [15:0] m);
    int best = 15;
    for (int i = 0; i < 13; i++)
      if (s[i] && m[tbBit(i)] && tbLvl(i) < best) best = tbLvl(i);
    return 4'(best) ^ 4'hF;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busValid = 0;
    d = busRdata;
  endtask

  task automatic setSrc(input logic [12:0] v);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] r;
    check("R1 irlCode", 16'(irlCode), 16'h0);
    check("R1 outPort", outPort, 16'h0);
    check("R1 powerOffReq", 16'(powerOffReq), 16'h0);
    check("R1 busRdata", busRdata, 16'h0);
    busRd(6'h00, r);
    check("R1 mask", r, 16'h0);
    setSrc(13'h1FFF);
    check("R1 pending masked by zero mask", 16'(irlCode), 16'h0);
    setSrc('0);
  endtask

  task automatic testEachSource();
    for (int i = 0; i < 13; i++) begin
      busWr(6'h00, 16'(1) << tbBit(i));
      setSrc(13'(1) << i);
      check($sformatf("R2 source %0d alone", i), 16'(irlCode), 16'(4'(tbLvl(i)) ^ 4'hF));
      busWr(6'h00, ~(16'(1) << tbBit(i)));
      check($sformatf("R2 source %0d masked", i), 16'(irlCode), 16'h0);
      setSrc('0);
    end
  endtask

  task automatic testPriority();
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] m;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = (k % 3 == 0) ? 16'hFFFF : {lfsr[7:0], lfsr[15:8]};
      busWr(6'h00, m);
      setSrc(lfsr[12:0]);
      check($sformatf("R3 pattern %0d", k), 16'(irlCode), 16'(expCode(lfsr[12:0], m)));
    end
    busWr(6'h00, 16'hFFFF);
    setSrc('0);
    check("R4 all enabled nothing pending", 16'(irlCode), 16'h0);
    setSrc(13'h1000);
    check("R3 lowest priority alone", 16'(irlCode), 16'h3);
    setSrc(13'h1008);
    check("R3 level0 beats level12", 16'(irlCode), 16'hF);
  endtask

  task automatic testRace();
    logic [15:0] r;
    busWr(6'h00, 16'h0000);
    setSrc('0);
    // Raise source 4 and unmask it in the same cycle
    @(negedge clk);
    srcIn = 13'h0010;
    busValid = 1; busWrite = 1; busAddr = 6'h00; busWdata = 16'h0400;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    check("R5 same-cycle unmask and raise", 16'(irlCode), 16'(expCode(13'h0010, 16'h0400)));
    // Mask source 4 while source 7 rises
    @(negedge clk);
    srcIn = 13'h0090;
    busValid = 1; busWrite = 1; busAddr = 6'h00; busWdata = 16'h0010;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    check("R5 same-cycle mask and raise", 16'(irlCode), 16'(expCode(13'h0090, 16'h0010)));
    busRd(6'h00, r);
    check("R6 mask readback", r, 16'h0010);
    setSrc('0);
    check("R5 line drop clears code", 16'(irlCode), 16'h0);
  endtask

  task automatic testPort();
    logic [15:0] r;
    busWr(6'h36, 16'hBEEF);
    check("R7 outPort drive", outPort, 16'hBEEF);
    busRd(6'h36, r);
    check("R7 port readback", r, 16'hBEEF);
    busWr(6'h00, 16'h1234);
    check("R7 port holds", outPort, 16'hBEEF);
  endtask

  task automatic testVersion();
    logic [15:0] r;
    busWr(6'h32, 16'hFFFF);
    busRd(6'h32, r);
    check("R8 version after write", r, 16'h0010);
    check("R8 write leaves port", outPort, 16'hBEEF);
  endtask

  task automatic testPowerOff();
    logic [15:0] r;
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = 6'h30; busWdata = 16'h0001;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    check("R9 pulse high", 16'(powerOffReq), 16'h1);
    @(negedge clk);
    check("R9 pulse one cycle", 16'(powerOffReq), 16'h0);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = 6'h30; busWdata = 16'hFFFE;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    check("R9 bit0 clear no pulse", 16'(powerOffReq), 16'h0);
    busRd(6'h30, r);
    check("R9 reads zero", r, 16'h0);
  endtask

  task automatic testUnmapped();
    logic [15:0] r;
    busWr(6'h02, 16'hAAAA);
    busWr(6'h01, 16'h5555);
    busWr(6'h37, 16'h5555);
    busWr(6'h3E, 16'h0F0F);
    busRd(6'h00, r);
    check("R10 mask untouched", r, 16'h1234);
    check("R10 port untouched", outPort, 16'hBEEF);
    busRd(6'h02, r);
    check("R10 unmapped reads zero", r, 16'h0);
    busRd(6'h37, r);
    check("R10 odd offset reads zero", r, 16'h0);
  endtask

  task automatic testReadTiming();
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = 6'h32;
    #1;
    check("R11 not before edge", busRdata, 16'h0);
    @(negedge clk);
    busValid = 0;
    check("R11 data after one cycle", busRdata, 16'h0010);
    @(negedge clk);
    check("R11 zero without read", busRdata, 16'h0);
  endtask

  initial begin
    rstN = 0; srcIn = '0; busValid = 0; busWrite = 0; busAddr = '0; busWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testEachSource();
    testPriority();
    testRace();
    testPort();
    testVersion();
    testPowerOff();
    testUnmapped();
    testReadTiming();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule